// File: doc/BRIEF.md
# Machine Cycle Phase Generator

This block is the timing front end of an 8-bit microcontroller core. Running directly on the oscillator clock, it halves that clock into a two-phase internal clock with an even duty cycle. It then counts the phases through six states, so that one machine cycle always lasts twelve oscillator periods. From that position it derives three things: a one-period marker at the start of each machine cycle, an address-latch strobe that fires twice per machine cycle, and the reset that the core actually obeys.

The external reset pin is filtered in step with the clock. A request counts only after it has been seen high on twelve consecutive oscillator edges, and any shorter pulse is thrown away. Once the core reset is active, it is released only at a machine-cycle boundary. The divider and the state counter are never touched by the external reset. Only the power-on input clears them, so the alignment of the machine cycle to the oscillator survives every warm reset.

Top module: `mc_phase_gen`

## Requirements
- R1: While `porN` is low, the outputs are: `stateIdx` = 0 (state S1), `phaseIdx` = 0 (phase P1), `phaseClk` = 1, `cycleStart` = 1, `ale` = 0 and `coreRst` = 1.
- R2: `phaseIdx` toggles on every oscillator rising edge. `phaseClk` is high exactly while `phaseIdx` = 0, which gives a 50% duty cycle at half the oscillator rate.
- R3: `stateIdx` advances by one on each edge that ends phase P2 (`phaseIdx` = 1), and wraps from 5 to 0. One machine cycle is therefore 12 oscillator periods.
- R4: `cycleStart` is high exactly when `stateIdx` = 0 and `phaseIdx` = 1'b0. It is one oscillator period wide and recurs once every 12 periods.
- R5: `ale` is high during S1P2, S2P1, S4P2 and S5P1. That is two pulses per machine cycle, each two oscillator periods long, at one sixth of the oscillator rate.
- R6: `extRst` is sampled on oscillator rising edges. `coreRst` goes high right after the 12th consecutive edge at which `extRst` is high, and not before.
- R7: A run of fewer than 12 high samples has no effect on `coreRst`, and a single low sample restarts the count from zero.
- R8: Once asserted, `coreRst` stays high until the first edge that enters S1P1 with `extRst` sampled low. It falls at that edge.
- R9: Neither `extRst` nor `coreRst` changes the sequence of `phaseIdx`, `stateIdx`, `cycleStart` or `ale`.
- R10: After power-on, with `extRst` low, `coreRst` falls at the first machine-cycle boundary, which is 12 oscillator edges after `porN` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Oscillator clock |
| porN | input | 1 | Asynchronous power-on clear, active low |
| extRst | input | 1 | External reset request, active high, sampled synchronously |
| phaseClk | output | 1 | Internal phase clock, high during P1 |
| phaseIdx | output | 1 | Current phase: 0 = P1, 1 = P2 |
| stateIdx | output | 3 | Current state, 0..5 for S1..S6 |
| cycleStart | output | 1 | High during S1P1 |
| ale | output | 1 | Address-latch strobe |
| coreRst | output | 1 | Qualified internal reset, active high |

## Verification
The divider and state sequence are compared with an oscillator-edge count kept by the bench. They are checked right after power-on and through several machine cycles, which shows whether the wrap point, the marker position and the strobe placement are correct. The reset filter is driven in three ways. The first is two eleven-edge pulses separated by a single low sample, which separates a true consecutive-hold count from a cumulative one. The second is a hold of exactly twelve edges, which pins down the edge on which the reset asserts. The third is a release followed by a brief re-assertion before the boundary, which shows that release waits for a boundary sampled low. The timing outputs are checked on every cycle of these reset patterns, so any realignment caused by reset is caught.

// File: rtl/mc_phase_pkg.sv
package mc_phase_pkg;

  // Strobes handed from the phase datapath to the reset control.
  typedef struct packed {
    logic lastPhase;   // next rising edge enters S1P1
    logic cycleStart;  // currently in S1P1
  } phaseStrobe_t;

  function automatic int unsigned stateBits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mc_phase_dp.sv
module mc_phase_dp
  import mc_phase_pkg::*;
#(
  parameter int unsigned NUM_STATES  = 6,
  parameter int unsigned ALE_STATE_A = 0,
  parameter int unsigned ALE_STATE_B = 3,
  localparam int unsigned STW        = stateBits(NUM_STATES)
) (
  input  logic           oscClk,
  input  logic           porN,
  output logic           phaseIdx,
  output logic [STW-1:0] stateIdx,
  output logic           aleOut,
  output phaseStrobe_t   strobe
);

  localparam logic [STW-1:0] LAST_STATE = STW'(NUM_STATES - 1);
  localparam logic [STW-1:0] ALE_A      = STW'(ALE_STATE_A);
  localparam logic [STW-1:0] ALE_B      = STW'(ALE_STATE_B);
  localparam logic [STW-1:0] ALE_A_NEXT = STW'((ALE_STATE_A + 1) % NUM_STATES);
  localparam logic [STW-1:0] ALE_B_NEXT = STW'((ALE_STATE_B + 1) % NUM_STATES);

  logic           phaseQ;
  logic [STW-1:0] stateQ;

  // Divide by two: phase flips each oscillator edge.
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) phaseQ <= 1'b0;
    else       phaseQ <= ~phaseQ;
  end

  // State counter advances at the end of P2.
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      stateQ <= '0;
    end else if (phaseQ) begin
      if (stateQ == LAST_STATE) stateQ <= '0;
      else                      stateQ <= stateQ + 1'b1;
    end
  end

  // Strobe: P2 of the chosen state plus P1 of the following state.
  always_comb begin
    aleOut = 1'b0;
    if (phaseQ  && (stateQ == ALE_A))      aleOut = 1'b1;
    if (!phaseQ && (stateQ == ALE_A_NEXT)) aleOut = 1'b1;
    if (phaseQ  && (stateQ == ALE_B))      aleOut = 1'b1;
    if (!phaseQ && (stateQ == ALE_B_NEXT)) aleOut = 1'b1;
  end

  always_comb begin
    strobe.cycleStart = (stateQ == '0) && !phaseQ;
    strobe.lastPhase  = (stateQ == LAST_STATE) && phaseQ;
  end

  assign phaseIdx = phaseQ;
  assign stateIdx = stateQ;

  // R3: state holds across P1 and steps once P2 ends.
  p_state_hold_r3: assert property (@(posedge oscClk) disable iff (!porN)
    !phaseQ |=> (stateQ == $past(stateQ)));

  // R3: the last state wraps to the first.
  p_state_wrap_r3: assert property (@(posedge oscClk) disable iff (!porN)
    strobe.lastPhase |=> strobe.cycleStart);

  // R4: the marker is never two periods wide.
  p_marker_single_r4: assert property (@(posedge oscClk) disable iff (!porN)
    strobe.cycleStart |=> !strobe.cycleStart);

  // R5: each strobe pulse lasts exactly two periods.
  p_ale_width_r5: assert property (@(posedge oscClk) disable iff (!porN)
    $rose(aleOut) |=> aleOut);
  p_ale_end_r5: assert property (@(posedge oscClk) disable iff (!porN)
    (aleOut && $past(aleOut)) |=> !aleOut);

endmodule

// File: rtl/mc_reset_ctl.sv
module mc_reset_ctl
  import mc_phase_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 12,
  localparam int unsigned CW         = $clog2(HOLD_CYCLES + 1)
) (
  input  logic         oscClk,
  input  logic         porN,
  input  logic         extRst,
  input  phaseStrobe_t strobe,
  output logic         coreRst
);

  localparam logic [CW-1:0] HOLD_LIMIT = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] holdCnt;
  logic          rstQ;

  // Consecutive-high counter: any low sample restarts it.
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      holdCnt <= '0;
    end else if (!extRst) begin
      holdCnt <= '0;
    end else if (holdCnt != HOLD_LIMIT) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // Assert on the final qualifying sample; release only at a boundary.
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      rstQ <= 1'b1;
    end else if (extRst && (holdCnt == HOLD_LAST)) begin
      rstQ <= 1'b1;
    end else if (!extRst && strobe.lastPhase) begin
      rstQ <= 1'b0;
    end
  end

  assign coreRst = rstQ;

  // R6: an assertion follows a high sample.
  p_rise_needs_req_r6: assert property (@(posedge oscClk) disable iff (!porN)
    $rose(coreRst) |-> $past(extRst));

  // R8: release lands on S1P1 and follows a low sample.
  p_release_on_boundary_r8: assert property (@(posedge oscClk) disable iff (!porN)
    $fell(coreRst) |-> (strobe.cycleStart && !$past(extRst)));

  // R7: a low sample never leaves a partial count behind.
  p_count_clears_r7: assert property (@(posedge oscClk) disable iff (!porN)
    !extRst |=> (holdCnt == '0));

endmodule

// File: rtl/mc_phase_gen.sv
module mc_phase_gen
  import mc_phase_pkg::*;
#(
  parameter int unsigned NUM_STATES  = 6,
  parameter int unsigned HOLD_CYCLES = 12,
  parameter int unsigned ALE_STATE_A = 0,
  parameter int unsigned ALE_STATE_B = 3,
  localparam int unsigned STW        = stateBits(NUM_STATES)
) (
  input  logic           oscClk,
  input  logic           porN,
  input  logic           extRst,
  output logic           phaseClk,
  output logic           phaseIdx,
  output logic [STW-1:0] stateIdx,
  output logic           cycleStart,
  output logic           ale,
  output logic           coreRst
);

  phaseStrobe_t strobe;

  mc_phase_dp #(
    .NUM_STATES (NUM_STATES),
    .ALE_STATE_A(ALE_STATE_A),
    .ALE_STATE_B(ALE_STATE_B)
  ) phaseDp_i (
    .oscClk  (oscClk),
    .porN    (porN),
    .phaseIdx(phaseIdx),
    .stateIdx(stateIdx),
    .aleOut  (ale),
    .strobe  (strobe)
  );

  mc_reset_ctl #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) resetCtl_i (
    .oscClk (oscClk),
    .porN   (porN),
    .extRst (extRst),
    .strobe (strobe),
    .coreRst(coreRst)
  );

  assign phaseClk   = ~phaseIdx;
  assign cycleStart = strobe.cycleStart;

endmodule

// File: tb/mc_phase_gen_tb_top.sv
module mc_phase_gen_tb_top;

  logic       oscClk = 1'b0;
  logic       porN   = 1'b0;
  logic       extRst = 1'b0;
  logic       phaseClk, phaseIdx, cycleStart, ale, coreRst;
  logic [2:0] stateIdx;

  int checks   = 0;
  int failures = 0;
  int edgeCnt  = 0;   // rising edges since power-on release
  bit done     = 1'b0;

  always #4 oscClk = ~oscClk;   // 125 MHz

  mc_phase_gen dut_i (
    .oscClk(oscClk), .porN(porN), .extRst(extRst),
    .phaseClk(phaseClk), .phaseIdx(phaseIdx), .stateIdx(stateIdx),
    .cycleStart(cycleStart), .ale(ale), .coreRst(coreRst)
  );

  always @(posedge oscClk or negedge porN) begin
    if (!porN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, edgeCnt);
    end
  endtask

  // Compare all timing outputs with the edge-count model.
  task automatic checkTiming(input string why);
    int m;
    m = edgeCnt % 12;
    check({"R2 phaseIdx ", why}, phaseIdx, m % 2);
    check({"R2 phaseClk ", why}, phaseClk, (m % 2 == 0) ? 1 : 0);
    check({"R3 stateIdx ", why}, stateIdx, m / 2);
    check({"R4 cycleStart ", why}, cycleStart, (m == 0) ? 1 : 0);
    check({"R5 ale ", why}, ale, (m == 1 || m == 2 || m == 7 || m == 8) ? 1 : 0);
  endtask

  task automatic t_power_on;
    porN = 1'b0;
    repeat (3) @(negedge oscClk);
    check("R1 stateIdx", stateIdx, 0);
    check("R1 phaseIdx", phaseIdx, 0);
    check("R1 phaseClk", phaseClk, 1);
    check("R1 cycleStart", cycleStart, 1);
    check("R1 ale", ale, 0);
    check("R1 coreRst", coreRst, 1);
    porN = 1'b1;
    for (int i = 1; i <= 36; i++) begin
      @(negedge oscClk);
      checkTiming("run");
      check("R10 coreRst after power-on", coreRst, (edgeCnt < 12) ? 1 : 0);
    end
  endtask

  task automatic t_short_hold;
    repeat (3) @(negedge oscClk);
    for (int p = 0; p < 2; p++) begin
      extRst = 1'b1;
      for (int i = 0; i < 11; i++) begin
        @(negedge oscClk);
        checkTiming("R9 short hold");
        check("R7 short hold ignored", coreRst, 0);
      end
      extRst = 1'b0;
      @(negedge oscClk);
      check("R7 count cleared by low", coreRst, 0);
    end
    repeat (5) begin
      @(negedge oscClk);
      check("R7 no late reset", coreRst, 0);
    end
  endtask

  task automatic releaseAndCheck(input string why);
    extRst = 1'b0;
    for (int i = 0; i < 13; i++) begin
      @(negedge oscClk);
      checkTiming("R9 release");
      if (edgeCnt % 12 == 0) begin
        check({"R8 release at boundary ", why}, coreRst, 0);
        break;
      end
      check({"R8 held until boundary ", why}, coreRst, 1);
    end
  endtask

  task automatic t_full_hold(input int offset);
    repeat (offset) @(negedge oscClk);
    extRst = 1'b1;
    for (int i = 1; i <= 11; i++) begin
      @(negedge oscClk);
      checkTiming("R9 hold");
      check("R6 not before 12th edge", coreRst, 0);
    end
    @(negedge oscClk);
    check("R6 asserted after 12th edge", coreRst, 1);
    checkTiming("R9 hold");
    repeat (7) begin
      @(negedge oscClk);
      checkTiming("R9 held");
      check("R6 stays asserted", coreRst, 1);
    end
    releaseAndCheck("plain");
  endtask

  task automatic t_reassert_before_boundary;
    extRst = 1'b1;
    repeat (12) @(negedge oscClk);
    check("R6 asserted", coreRst, 1);
    while (edgeCnt % 12 != 9) @(negedge oscClk);
    extRst = 1'b0;
    @(negedge oscClk);
    extRst = 1'b1;   // high again across the boundary edge
    repeat (3) begin
      @(negedge oscClk);
      checkTiming("R9 reassert");
      check("R8 no release while high at boundary", coreRst, 1);
    end
    releaseAndCheck("after reassert");
  endtask

  initial begin
    t_power_on();
    t_short_hold();
    t_full_hold(1);
    t_full_hold(6);
    t_reassert_before_boundary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule